// File: doc/BRIEF.md
# Read/Write Byte Mask Datapath

This block is the data path between a memory core and a 32-bit bidirectional data bus that has four byte-mask inputs. On a write, the byte masks gate the core's byte enables combinationally, so a masked byte is blocked in the same cycle its mask is sampled. On a read, core data enters a pipeline whose depth is the programmed read latency (1, 2 or 3 clocks). Each byte's output driver is turned off by a mask sampled two clocks earlier. The bus itself is presented as a data-out vector with one output enable per byte lane; a lane whose enable is low is at high impedance.

A clock-enable input freezes the read pipeline, the mask delay line and therefore the bus outputs. While it is low, writes to the core are suppressed and any read or mask on the inputs is ignored.

Top module: `byte_mask_datapath`

## Requirements
- R1: After a synchronous active-low reset, every bit of `bus_oe` is low until a read has travelled through the pipeline.
- R2: When `wr_en` and `cke` are both high, `core_we` is high in the same cycle and `core_wdata` equals `bus_din`; otherwise `core_we` is low.
- R3: During an active write, `core_wbe[i]` is the inverse of `byte_mask[i]`, where lane i covers data bits 8i+7 down to 8i (lane 3 is bits 31..24, lane 0 is bits 7..0); when no write is active, `core_wbe` is all zero.
- R4: A read sampled at clock edge k (with `rd_en` high and `core_rdata` valid) appears on `bus_dout` with its lanes enabled during the cycle after edge k+L-1, where L is the value of `lat_sel` (binary 1, 2 or 3); a `lat_sel` of 0 behaves as 1.
- R5: `bus_oe` is all zero in any cycle that carries no read data from the latency pipeline.
- R6: A mask bit sampled high at edge m disables that lane's output enable in the cycle after edge m+1, i.e. for the data the bus consumer samples at edge m+2.
- R7: A read mask affects only the one bus cycle it is timed to; the next read-data cycle is unmasked unless masked again.
- R8: While `cke` is low at an edge, the read pipeline and mask delay line hold their state, `bus_dout` and `bus_oe` stay frozen, and the read request and masks sampled at that edge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the read side and blocks writes |
| lat_sel | input | 2 | Read latency in clocks (1..3; 0 acts as 1) |
| byte_mask | input | 4 | Per-lane byte mask, bit i covers bits 8i+7..8i |
| wr_en | input | 1 | Write cycle request from the bus side |
| bus_din | input | 32 | Write data from the bus |
| core_we | output | 1 | Write strobe to the core |
| core_wbe | output | 4 | Byte enables to the core |
| core_wdata | output | 32 | Write data to the core |
| rd_en | input | 1 | Core read data valid this cycle |
| core_rdata | input | 32 | Read data from the core |
| bus_dout | output | 32 | Read data toward the bus |
| bus_oe | output | 4 | Per-lane bus output enable (low means high impedance) |

## Verification
The assertions take for granted that `lat_sel` is not changed while a read is in flight; the latency property tolerates a change by excusing cycles where the selected latency differs, and the bench only reprograms the latency after the pipeline has drained. They also rely on reset being held low from time zero, which the bench does for several cycles before any stimulus. Inputs are driven on the falling clock edge so every mask, read and clock-enable value is stable across the sampling edge.

// File: rtl/bmd_pkg.sv
// Package: shared constants for the byte mask datapath.
// Assumes byte-sized lanes and a fixed two-clock read-mask delay.
package bmd_pkg;
    localparam int BMD_LANE_W   = 8;  // bits per mask lane
    localparam int BMD_MASK_DLY = 2;  // read-mask delay in clocks
endpackage

// File: rtl/bmd_write_gate.sv
// Write gate: forms the core write strobe and per-lane byte enables
// from the bus write request and the byte masks, with no register stage.
// Assumes the masks are sampled in the same cycle as the write data.
module bmd_write_gate #(
    parameter int DATA_W = 32,
    parameter int NLANE  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              wr_en,
    input  logic [NLANE-1:0]  byte_mask,
    input  logic [DATA_W-1:0] bus_din,
    output logic              core_we,
    output logic [NLANE-1:0]  core_wbe,
    output logic [DATA_W-1:0] core_wdata
);
    logic wr_live;

    // Purpose: a write only proceeds when the clock is enabled.
    always_comb begin
        wr_live    = wr_en & cke;
        core_we    = wr_live;
        core_wbe   = wr_live ? ~byte_mask : '0;
        core_wdata = bus_din;
    end

    // R3: a masked lane never reaches the core during a write
    p_wbe_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        core_we |-> ((core_wbe & byte_mask) == '0));
    // R3: no byte enable outside a write
    p_wbe_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !core_we |-> (core_wbe == '0));
endmodule

// File: rtl/bmd_read_pipe.sv
// Read latency pipeline: a chain of MAX_LAT valid/data stages that
// advances only with clock enable; the stage picked by lat_idx drives out.
// Assumes lat_idx is held steady while reads are in flight.
module bmd_read_pipe #(
    parameter int DATA_W  = 32,
    parameter int MAX_LAT = 3,
    localparam int IDX_W  = $clog2(MAX_LAT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  lat_idx,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    logic [MAX_LAT-1:0]             vld_q;
    logic [MAX_LAT-1:0][DATA_W-1:0] dat_q;

    for (genvar s = 0; s < MAX_LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            // Purpose: capture a fresh read beat from the core.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[0] <= 1'b0;
                    dat_q[0] <= '0;
                end else if (cke) begin
                    vld_q[0] <= rd_en;
                    dat_q[0] <= rd_data;
                end
            end
        end else begin : g_tail
            // Purpose: move the beat one stage further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[s] <= 1'b0;
                    dat_q[s] <= '0;
                end else if (cke) begin
                    vld_q[s] <= vld_q[s-1];
                    dat_q[s] <= dat_q[s-1];
                end
            end
        end
    end

    // Purpose: tap the stage that matches the programmed latency.
    always_comb begin
        out_vld  = vld_q[lat_idx];
        out_data = dat_q[lat_idx];
    end

    // R8: the chain holds while the clock is disabled
    p_pipe_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(vld_q) && $stable(dat_q)));
    // R4: at latency one a read is on the bus after the next edge
    p_lat_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && rd_en && lat_idx == '0) |=> (lat_idx != '0 || out_vld));
endmodule

// File: rtl/bmd_mask_delay.sv
// Read-mask delay line: carries each lane mask DLY clocks so it lines up
// with the bus cycle it governs; advances only with clock enable.
// Assumes DLY is at least one.
module bmd_mask_delay #(
    parameter int NLANE = 4,
    parameter int DLY   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cke,
    input  logic [NLANE-1:0] mask_in,
    output logic [NLANE-1:0] mask_out
);
    logic [DLY-1:0][NLANE-1:0] mq;

    for (genvar d = 0; d < DLY; d++) begin : g_tap
        // Purpose: one clock of mask delay.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mq[d] <= '0;
            else if (cke)
                mq[d] <= (d == 0) ? mask_in : mq[(d == 0) ? 0 : d-1];
        end
    end

    assign mask_out = mq[DLY-1];

    // R8: the delayed mask holds while the clock is disabled
    p_mask_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> $stable(mask_out));
endmodule

// File: rtl/byte_mask_datapath.sv
// Top: byte-masked data path between a memory core and a bus.
// Writes are gated in the same cycle; reads go through a latency
// pipeline and are lane-masked by masks sampled two clocks earlier.
// Assumes lat_sel is changed only while no read is in flight.
module byte_mask_datapath #(
    parameter int DATA_W  = 32,
    parameter int MAX_LAT = 3,
    localparam int NLANE  = DATA_W / bmd_pkg::BMD_LANE_W,
    localparam int SEL_W  = $clog2(MAX_LAT + 1),
    localparam int IDX_W  = $clog2(MAX_LAT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic [SEL_W-1:0]  lat_sel,
    input  logic [NLANE-1:0]  byte_mask,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] bus_din,
    output logic              core_we,
    output logic [NLANE-1:0]  core_wbe,
    output logic [DATA_W-1:0] core_wdata,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] core_rdata,
    output logic [DATA_W-1:0] bus_dout,
    output logic [NLANE-1:0]  bus_oe
);
    logic [IDX_W-1:0]  lat_idx;
    logic              rd_vld;
    logic [DATA_W-1:0] rd_dat;
    logic [NLANE-1:0]  mask_late;

    // Purpose: map the programmed latency to a pipeline stage index.
    always_comb begin
        if (lat_sel == '0)
            lat_idx = '0;
        else if (int'(lat_sel) > MAX_LAT)
            lat_idx = IDX_W'(MAX_LAT - 1);
        else
            lat_idx = IDX_W'(int'(lat_sel) - 1);
    end

    bmd_write_gate #(.DATA_W(DATA_W), .NLANE(NLANE)) u_wr (
        .clk(clk), .rst_n(rst_n), .cke(cke), .wr_en(wr_en),
        .byte_mask(byte_mask), .bus_din(bus_din),
        .core_we(core_we), .core_wbe(core_wbe), .core_wdata(core_wdata)
    );

    bmd_read_pipe #(.DATA_W(DATA_W), .MAX_LAT(MAX_LAT)) u_rd (
        .clk(clk), .rst_n(rst_n), .cke(cke), .rd_en(rd_en),
        .rd_data(core_rdata), .lat_idx(lat_idx),
        .out_vld(rd_vld), .out_data(rd_dat)
    );

    bmd_mask_delay #(.NLANE(NLANE), .DLY(bmd_pkg::BMD_MASK_DLY)) u_mk (
        .clk(clk), .rst_n(rst_n), .cke(cke),
        .mask_in(byte_mask), .mask_out(mask_late)
    );

    // Purpose: drive a lane only for valid read data it is not masked on.
    always_comb begin
        bus_dout = rd_dat;
        bus_oe   = {NLANE{rd_vld}} & ~mask_late;
    end

    // R5: no lane is driven without read data in the output stage
    p_oe_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe != '0) |-> rd_vld);
    // R8: bus outputs are frozen across a disabled clock
    p_bus_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $stable(lat_sel)) |=> ($stable(bus_oe) && $stable(bus_dout)));
    // R2: the core never sees a write while the clock is disabled
    p_no_write_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !core_we);
endmodule

// File: tb/sim_byte_mask_datapath.sv
module sim_byte_mask_datapath;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1;
    logic [1:0]  lat_sel = 2'd2;
    logic [3:0]  byte_mask = '0;
    logic        wr_en = 1'b0;
    logic [31:0] bus_din = '0;
    logic        core_we;
    logic [3:0]  core_wbe;
    logic [31:0] core_wdata;
    logic        rd_en = 1'b0;
    logic [31:0] core_rdata = '0;
    logic [31:0] bus_dout;
    logic [3:0]  bus_oe;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    byte_mask_datapath u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .lat_sel(lat_sel),
        .byte_mask(byte_mask), .wr_en(wr_en), .bus_din(bus_din),
        .core_we(core_we), .core_wbe(core_wbe), .core_wdata(core_wdata),
        .rd_en(rd_en), .core_rdata(core_rdata),
        .bus_dout(bus_dout), .bus_oe(bus_oe)
    );

    // Stimulus per cycle at latency 2 and the outputs expected in that cycle:
    // {cke, rd_en, core_rdata, byte_mask, exp_oe, exp_dout}
    typedef struct packed {
        logic        c;
        logic        r;
        logic [31:0] d;
        logic [3:0]  m;
        logic [3:0]  eo;
        logic [31:0] ed;
    } vec_t;
    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{1'b1, 1'b1, 32'h11111111, 4'h0, 4'h0, 32'h0},        // R5
        '{1'b1, 1'b1, 32'h22222222, 4'h5, 4'h0, 32'h0},        // R5
        '{1'b1, 1'b0, 32'h0,        4'h0, 4'hF, 32'h11111111}, // R4
        '{1'b1, 1'b1, 32'h33333333, 4'h8, 4'hA, 32'h22222222}, // R6
        '{1'b1, 1'b0, 32'h0,        4'h0, 4'h0, 32'h0},        // R5
        '{1'b1, 1'b0, 32'h0,        4'h2, 4'h7, 32'h33333333}, // R6
        '{1'b1, 1'b1, 32'h44444444, 4'h0, 4'h0, 32'h0},        // R5
        '{1'b1, 1'b1, 32'h55555555, 4'h0, 4'h0, 32'h0},        // R5
        '{1'b1, 1'b0, 32'h0,        4'h0, 4'hF, 32'h44444444}, // R7
        '{1'b0, 1'b1, 32'h66666666, 4'hF, 4'hF, 32'h55555555}, // R8
        '{1'b1, 1'b1, 32'h77777777, 4'h0, 4'hF, 32'h55555555}, // R8
        '{1'b1, 1'b0, 32'h0,        4'h0, 4'h0, 32'h0},        // R8
        '{1'b1, 1'b0, 32'h0,        4'h0, 4'hF, 32'h77777777}, // R8
        '{1'b1, 1'b0, 32'h0,        4'h0, 4'h0, 32'h0}         // R5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive inputs on the falling edge, then let combinational outputs settle.
    task automatic cyc(input logic c, input logic r, input logic [31:0] d,
                       input logic [3:0] m, input logic w, input logic [31:0] wd);
        @(negedge clk);
        cke = c; rd_en = r; core_rdata = d; byte_mask = m; wr_en = w; bus_din = wd;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        // R1: reset state, with a read held at the inputs
        repeat (4) cyc(1, 1, 32'hDEADBEEF, 4'h0, 0, 0);
        chk("R1 oe in reset", {28'h0, bus_oe}, 32'h0);
        cyc(1, 0, 0, 4'h0, 0, 0);
        rst_n = 1'b1;
        cyc(1, 0, 0, 4'h0, 0, 0);
        chk("R1 oe after reset", {28'h0, bus_oe}, 32'h0);

        // Vector walk at latency 2
        for (int i = 0; i < NV; i++) begin
            cyc(VT[i].c, VT[i].r, VT[i].d, VT[i].m, 0, 0);
            chk($sformatf("R4/R5/R6/R7/R8 oe row %0d", i), {28'h0, bus_oe}, {28'h0, VT[i].eo});
            if (VT[i].eo != 4'h0)
                chk($sformatf("R4 data row %0d", i), bus_dout, VT[i].ed);
        end

        // R2 R3: writes gated in the same cycle
        cyc(1, 0, 0, 4'h6, 1, 32'hCAFEF00D);
        chk("R2 we", {31'h0, core_we}, 32'h1);
        chk("R2 wdata", core_wdata, 32'hCAFEF00D);
        chk("R3 wbe masked", {28'h0, core_wbe}, 32'h9);
        cyc(1, 0, 0, 4'h0, 1, 32'h01020304);
        chk("R3 wbe full", {28'h0, core_wbe}, 32'hF);
        cyc(0, 0, 0, 4'h0, 1, 32'h01020304);
        chk("R2 we blocked by cke", {31'h0, core_we}, 32'h0);
        chk("R3 wbe blocked by cke", {28'h0, core_wbe}, 32'h0);
        cyc(1, 0, 0, 4'h0, 0, 0);
        chk("R2 idle we", {31'h0, core_we}, 32'h0);

        // R4: latency 1 and 3, and 0 acting as 1
        foreach (lat_sel_list[k]) begin end
        for (int l = 0; l < 4; l++) begin
            int eff;
            eff = (l == 0) ? 1 : l;
            repeat (4) cyc(1, 0, 0, 4'h0, 0, 0);
            lat_sel = 2'(l);
            cyc(1, 1, 32'hA5A50000 + 32'(l), 4'h0, 0, 0);
            for (int t = 1; t <= eff + 1; t++) begin
                cyc(1, 0, 0, 4'h0, 0, 0);
                chk($sformatf("R4 lat=%0d t=%0d oe", l, t), {28'h0, bus_oe},
                    (t == eff) ? 32'hF : 32'h0);
                if (t == eff)
                    chk($sformatf("R4 lat=%0d data", l), bus_dout, 32'hA5A50000 + 32'(l));
            end
        end

        // R6: latency 1, mask one cycle ahead of the read hits that read
        lat_sel = 2'd1;
        repeat (3) cyc(1, 0, 0, 4'h0, 0, 0);
        cyc(1, 0, 0, 4'h1, 0, 0);
        cyc(1, 1, 32'h0BADF00D, 4'h0, 0, 0);
        cyc(1, 0, 0, 4'h0, 0, 0);
        chk("R6 lat1 mask lane0", {28'h0, bus_oe}, 32'hE);
        chk("R6 lat1 data", bus_dout, 32'h0BADF00D);

        // R1: reset mid-stream clears pending reads
        lat_sel = 2'd3;
        cyc(1, 1, 32'h12345678, 4'h0, 0, 0);
        rst_n = 1'b0;
        cyc(1, 0, 0, 4'h0, 0, 0);
        rst_n = 1'b1;
        repeat (3) begin
            cyc(1, 0, 0, 4'h0, 0, 0);
            chk("R1 flushed by reset", {28'h0, bus_oe}, 32'h0);
        end

        finish_run();
    end

    int lat_sel_list [1];
endmodule